// File: doc/BRIEF.md
# Counter Read Sanitiser

This block sits between a consumer and a 64-bit free-running counter whose low-order bits can be unreliable. When a carry moves into bit 10 or any higher bit, the low bits can read back too high or too low. A read taken at that moment can appear to step backward (for example 0x7FF, then 0x000, then 0x800) or jump forward (0x7FF, then 0xFFF, then 0x800). A read request makes the block sample the counter once per clock. It throws away every sample whose low ten bits are all zeros or all ones, and it returns the first sample that survives.

The number of samples per request is bounded. If every sample up to the bound is rejected, the block returns the last one anyway and marks the response as a give-up. It also sets a sticky warning and raises a one-cycle notice, and it does this only the first time a give-up happens. Each response also carries a 32-bit remaining-time value. This is a 64-bit compare value minus the returned count, truncated to 32 bits, so a timer driver can program its next event from a clean count.

Top module: `cnt_read_filter`

## Requirements
- R1: After reset, rd_done, rd_busy, rd_gaveup, warn and warn_first are all 0.
- R2: A request seen at a clock edge while idle takes its first sample of cnt_in at that same edge. When a sample is accepted, rd_done is high for exactly the cycle after that edge, and rd_data holds that sample.
- R3: A sample is rejected when bits [9:0] equal 0x000 or 0x3FF. Any other value of those bits is accepted, including 0x001 and 0x3FE. After a rejection, the next sample is taken at the following edge.
- R4: At most 150 samples are taken per request. The 150th sample is returned even if it fails the R3 check.
- R5: rd_gaveup is 1 with a response that returned a rejected 150th sample, and 0 with a response that returned a sample passing the R3 check.
- R6: A give-up sets warn. warn then stays 1 through later reads and is cleared only by reset.
- R7: warn_first is a one-cycle pulse beside rd_done for the first give-up after reset only. Later give-ups do not raise it.
- R8: rd_remain equals bits [31:0] of (cmp_val sampled at the accepting edge minus rd_data), modulo 2^64.
- R9: rd_req is ignored while a request is in progress. Holding it high through a long retry neither restarts the sample count nor produces an extra response.
- R10: rd_busy is 1 from the cycle after a rejected (non-final) sample until the response. It is 0 in the rd_done cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rd_req | input | 1 | Read request, sampled while idle |
| cnt_in | input | 64 | Live counter value |
| cmp_val | input | 64 | Compare value for the remaining-time result |
| rd_done | output | 1 | One-cycle response strobe |
| rd_data | output | 64 | Returned counter sample |
| rd_remain | output | 32 | cmp_val minus rd_data, low 32 bits |
| rd_gaveup | output | 1 | Response is an unfiltered last sample |
| rd_busy | output | 1 | Retry sampling in progress |
| warn | output | 1 | Sticky give-up warning |
| warn_first | output | 1 | One-cycle pulse on the first give-up |

## Verification
The bench drives the two R3 boundary neighbours, 0x001 and 0x3FE, and expects them accepted. A design that compared a wider or narrower field, or that was off by one in the (value+1) test, would reject them or let 0x000/0x3FF through. The bench runs full 150-sample exhaustions with rd_req held high throughout. A sampler that counts one too few or too many responds on the wrong cycle, and one that restarts on a repeated request never answers in time. A second exhaustion checks that the warning notice stays silent and the flag stays set. A compare value below the count checks that the remaining-time result wraps instead of saturating.

// File: rtl/crf_pkg.sv
package crf_pkg;

   typedef enum logic {
      CRF_IDLE = 1'b0,
      CRF_BUSY = 1'b1
   } crf_state_e;

   // Width of a counter of retries able to hold the value n-1
   function automatic int crf_cnt_w(input int n);
      return (n <= 2) ? 1 : $clog2(n);
   endfunction

endpackage

// File: rtl/crf_sample_judge.sv
module crf_sample_judge #(
   parameter int CNT_W   = 64,
   parameter int FIELD_W = 10
) (
   input  logic [CNT_W-1:0] sample,
   output logic             unsafe
);
   logic [FIELD_W-1:0] low_field;

   assign low_field = sample[FIELD_W-1:0];

   // All-zero or all-one low field: a carry may be in flight above it
   assign unsafe = (&low_field) | ~(|low_field);

endmodule

// File: rtl/crf_try_ctr.sv
module crf_try_ctr
   import crf_pkg::*;
#(
   parameter int MAX_TRIES = 150
) (
   input  logic clk,
   input  logic rst_n,
   input  logic clr,
   input  logic inc,
   output logic last
);
   localparam int TW = crf_cnt_w(MAX_TRIES);
   localparam logic [TW-1:0] LAST_IDX = TW'(MAX_TRIES - 1);

   logic [TW-1:0] rejected;

   always_ff @(posedge clk) begin
      if (!rst_n || clr) begin
         rejected <= '0;
      end else if (inc) begin
         rejected <= rejected + 1'b1;
      end
   end

   // The sample being taken now is the final one allowed
   assign last = (rejected == LAST_IDX);

endmodule

// File: rtl/crf_remain_calc.sv
module crf_remain_calc #(
   parameter int CNT_W     = 64,
   parameter int REM_W     = 32,
   parameter bit REMAIN_EN = 1'b1
) (
   input  logic [CNT_W-1:0] cmp_val,
   input  logic [CNT_W-1:0] count,
   output logic [REM_W-1:0] remain
);
   generate
      if (REMAIN_EN) begin : g_calc
         logic [CNT_W-1:0] diff;
         assign diff   = cmp_val - count;
         assign remain = diff[REM_W-1:0];
      end else begin : g_none
         assign remain = '0;
      end
   endgenerate

endmodule

// File: rtl/cnt_read_filter.sv
module cnt_read_filter
   import crf_pkg::*;
#(
   parameter int CNT_W     = 64,
   parameter int FIELD_W   = 10,
   parameter int MAX_TRIES = 150,
   parameter int REM_W     = 32,
   parameter bit REMAIN_EN = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             rd_req,
   input  logic [63:0]      cnt_in,
   input  logic [63:0]      cmp_val,
   output logic             rd_done,
   output logic [63:0]      rd_data,
   output logic [31:0]      rd_remain,
   output logic             rd_gaveup,
   output logic             rd_busy,
   output logic             warn,
   output logic             warn_first
);
   generate
      if (CNT_W != 64 || REM_W != 32) begin : g_bad_width
         $error("cnt_read_filter: port widths fixed at 64/32");
      end
      if (FIELD_W < 1 || FIELD_W >= CNT_W) begin : g_bad_field
         $error("cnt_read_filter: FIELD_W out of range");
      end
      if (MAX_TRIES < 2) begin : g_bad_tries
         $error("cnt_read_filter: MAX_TRIES must be at least 2");
      end
   endgenerate

   crf_state_e       state_q;
   logic             unsafe;
   logic             last;
   logic             take;
   logic             accept;
   logic [REM_W-1:0] remain_d;

   crf_sample_judge #(
      .CNT_W   (CNT_W),
      .FIELD_W (FIELD_W)
   ) u_judge (
      .sample (cnt_in),
      .unsafe (unsafe)
   );

   crf_try_ctr #(
      .MAX_TRIES (MAX_TRIES)
   ) u_tries (
      .clk   (clk),
      .rst_n (rst_n),
      .clr   (accept),
      .inc   (take && !accept),
      .last  (last)
   );

   crf_remain_calc #(
      .CNT_W     (CNT_W),
      .REM_W     (REM_W),
      .REMAIN_EN (REMAIN_EN)
   ) u_remain (
      .cmp_val (cmp_val),
      .count   (cnt_in),
      .remain  (remain_d)
   );

   assign take   = (state_q == CRF_BUSY) || rd_req;
   assign accept = take && (!unsafe || last);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q    <= CRF_IDLE;
         rd_done    <= 1'b0;
         rd_data    <= '0;
         rd_remain  <= '0;
         rd_gaveup  <= 1'b0;
         warn       <= 1'b0;
         warn_first <= 1'b0;
      end else begin
         rd_done    <= accept;
         warn_first <= accept && unsafe && !warn;
         if (accept) begin
            state_q   <= CRF_IDLE;
            rd_data   <= cnt_in;
            rd_remain <= remain_d;
            rd_gaveup <= unsafe;
            if (unsafe) begin
               warn <= 1'b1;
            end
         end else if (take) begin
            state_q <= CRF_BUSY;
         end
      end
   end

   assign rd_busy = (state_q == CRF_BUSY);

endmodule

// File: rtl/cnt_read_filter_chk.sv
module cnt_read_filter_chk #(
   parameter int CNT_W     = 64,
   parameter int FIELD_W   = 10,
   parameter int MAX_TRIES = 150,
   parameter int REM_W     = 32,
   parameter bit REMAIN_EN = 1'b1
) (
   input logic        clk,
   input logic        rst_n,
   input logic [63:0] cmp_val,
   input logic        rd_done,
   input logic [63:0] rd_data,
   input logic [31:0] rd_remain,
   input logic        rd_gaveup,
   input logic        rd_busy,
   input logic        warn,
   input logic        warn_first
);
   logic [15:0] busy_run;

   always_ff @(posedge clk) begin
      if (!rst_n || !rd_busy) begin
         busy_run <= '0;
      end else begin
         busy_run <= busy_run + 1'b1;
      end
   end

   AST_BUSY_NO_DONE: assert property (@(posedge clk) disable iff (!rst_n)
      rd_busy |-> !rd_done); // R10

   AST_CLEAN_RESULT: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_done && !rd_gaveup) |-> ((|rd_data[FIELD_W-1:0]) && !(&rd_data[FIELD_W-1:0]))); // R5

   AST_GAVEUP_WARN: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_done && rd_gaveup) |-> warn); // R6

   AST_WARN_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      warn |=> warn); // R6

   AST_WARN_FIRST_ONCE: assert property (@(posedge clk) disable iff (!rst_n)
      warn_first |-> ($rose(warn) && rd_done && rd_gaveup)); // R7

   AST_TRY_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
      rd_busy |-> (32'(busy_run) < 32'(MAX_TRIES - 1))); // R4

   generate
      if (REMAIN_EN) begin : g_rem_chk
         AST_REMAIN_VALUE: assert property (@(posedge clk) disable iff (!rst_n)
            rd_done |-> (rd_remain == 32'($past(cmp_val) - rd_data))); // R8
      end
   endgenerate

endmodule

bind cnt_read_filter cnt_read_filter_chk #(
   .CNT_W     (CNT_W),
   .FIELD_W   (FIELD_W),
   .MAX_TRIES (MAX_TRIES),
   .REM_W     (REM_W),
   .REMAIN_EN (REMAIN_EN)
) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .cmp_val    (cmp_val),
   .rd_done    (rd_done),
   .rd_data    (rd_data),
   .rd_remain  (rd_remain),
   .rd_gaveup  (rd_gaveup),
   .rd_busy    (rd_busy),
   .warn       (warn),
   .warn_first (warn_first)
);

// File: tb/cnt_read_filter_bench.sv
`timescale 1ns/1ps
module cnt_read_filter_bench;
   logic        clk = 1'b0;
   logic        rst_n;
   logic        rd_req;
   logic [63:0] cnt_in;
   logic [63:0] cmp_val;
   logic        rd_done;
   logic [63:0] rd_data;
   logic [31:0] rd_remain;
   logic        rd_gaveup;
   logic        rd_busy;
   logic        warn;
   logic        warn_first;

   int n_chk = 0;
   int n_err = 0;
   bit finished = 1'b0;

   always #2.5 clk = ~clk;

   cnt_read_filter u_cnt_read_filter (
      .clk        (clk),
      .rst_n      (rst_n),
      .rd_req     (rd_req),
      .cnt_in     (cnt_in),
      .cmp_val    (cmp_val),
      .rd_done    (rd_done),
      .rd_data    (rd_data),
      .rd_remain  (rd_remain),
      .rd_gaveup  (rd_gaveup),
      .rd_busy    (rd_busy),
      .warn       (warn),
      .warn_first (warn_first)
   );

   task automatic chk(input string req, input string what,
                      input logic [63:0] act, input logic [63:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_err++;
         $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
      end
   endtask

   task automatic tick();
      @(posedge clk);
      #1;
   endtask

   function automatic logic [63:0] rem_of(input logic [63:0] c, input logic [63:0] v);
      logic [63:0] d;
      d = c - v;
      return {32'b0, d[31:0]};
   endfunction

   function automatic logic [63:0] bad_val(input int k);
      logic [63:0] v;
      v = 64'h0000_00F0_0000_0000 + (64'(k) << 10);
      v[9:0] = k[0] ? 10'h3FF : 10'h000;
      return v;
   endfunction

   task automatic do_reset();
      rst_n = 1'b0; rd_req = 1'b0; cnt_in = '0; cmp_val = '0;
      tick(); tick();
      rst_n = 1'b1;
      tick();
   endtask

   task automatic t_reset();
      do_reset();
      chk("R1", "done",       64'(rd_done), 64'd0);
      chk("R1", "busy",       64'(rd_busy), 64'd0);
      chk("R1", "gaveup",     64'(rd_gaveup), 64'd0);
      chk("R1", "warn",       64'(warn), 64'd0);
      chk("R1", "warn_first", 64'(warn_first), 64'd0);
   endtask

   // One clean read: response in the cycle after the request edge
   task automatic t_clean(input logic [63:0] v, input logic [63:0] c, input string req);
      cnt_in = v; cmp_val = c; rd_req = 1'b1;
      tick();
      rd_req = 1'b0; cnt_in = 64'h0;
      chk(req, "done", 64'(rd_done), 64'd1);
      chk(req, "data", rd_data, v);
      chk("R5", "gaveup clean", 64'(rd_gaveup), 64'd0);
      chk("R8", "remain", 64'(rd_remain), rem_of(c, v));
      chk("R10", "busy at done", 64'(rd_busy), 64'd0);
      tick();
      chk("R2", "done one cycle", 64'(rd_done), 64'd0);
   endtask

   // Rejected samples 0x..7FF and 0x..C00 then an accepted one
   task automatic t_reject();
      cmp_val = 64'h0000_0000_0001_0000;
      cnt_in = 64'h0000_0000_0000_07FF; rd_req = 1'b1;
      tick();
      rd_req = 1'b0;
      chk("R3", "no done on 0x3FF low", 64'(rd_done), 64'd0);
      chk("R10", "busy after reject", 64'(rd_busy), 64'd1);
      cnt_in = 64'h0000_0000_0000_0C00;
      tick();
      chk("R3", "no done on 0x000 low", 64'(rd_done), 64'd0);
      cnt_in = 64'h0000_0000_0000_0801;
      cmp_val = 64'h0000_0000_0000_0900;
      tick();
      chk("R3", "done after resample", 64'(rd_done), 64'd1);
      chk("R3", "data after resample", rd_data, 64'h801);
      chk("R8", "remain at accept edge", 64'(rd_remain), 64'h0FF);
      chk("R10", "busy cleared", 64'(rd_busy), 64'd0);
      tick();
   endtask

   // 150 bad samples with rd_req held high all along
   task automatic t_exhaust(input logic first_expected);
      int early = 0;
      int notbusy = 0;
      cmp_val = 64'h0000_0000_0000_0010;
      for (int k = 0; k < 150; k++) begin
         cnt_in = bad_val(k);
         rd_req = 1'b1;
         tick();
         if (k < 149) begin
            if (rd_done) early++;
            if (!rd_busy) notbusy++;
         end
      end
      rd_req = 1'b0;
      chk("R9", "early responses while held", 64'(early), 64'd0);
      chk("R10", "busy during retries", 64'(notbusy), 64'd0);
      chk("R4", "done at 150th", 64'(rd_done), 64'd1);
      chk("R4", "last sample returned", rd_data, bad_val(149));
      chk("R5", "gaveup", 64'(rd_gaveup), 64'd1);
      chk("R6", "warn set", 64'(warn), 64'd1);
      chk("R7", "warn_first", 64'(warn_first), 64'(first_expected));
      chk("R8", "remain on giveup", 64'(rd_remain), rem_of(64'h10, bad_val(149)));
      tick();
      chk("R9", "no extra response", 64'(rd_done), 64'd0);
      chk("R7", "warn_first pulse", 64'(warn_first), 64'd0);
      chk("R6", "warn held", 64'(warn), 64'd1);
      chk("R10", "idle after giveup", 64'(rd_busy), 64'd0);
   endtask

   initial begin
      t_reset();
      t_clean(64'h1234_5678_9ABC_0155, 64'h1234_5678_9ABD_0000, "R2");
      t_clean(64'h0000_0000_0000_0401, 64'h0000_0000_0000_0500, "R3 low 0x001");
      t_clean(64'h0000_0000_0000_07FE, 64'h0000_0000_0000_0000, "R3 low 0x3FE");
      t_reject();
      t_exhaust(1'b1);
      t_clean(64'hFFFF_0000_1234_5677, 64'h0000_0000_0000_0001, "R6 clean after warn");
      chk("R6", "warn stays after clean", 64'(warn), 64'd1);
      t_exhaust(1'b0);
      do_reset();
      chk("R6", "warn cleared by reset", 64'(warn), 64'd0);
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      finished = 1'b1;
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!finished) begin
         n_chk++;
         n_err++;
         $display("FAIL watchdog: actual=hung expected=finished");
         $display("Result: errors=%0d of %0d checks", n_err, n_chk);
         $finish;
      end
   end

endmodule